// File: doc/BRIEF.md
# Protected Descriptor Update Filter

This block sits in front of the memory that holds 64-bit translation descriptors. It checks every write aimed at that memory. For each write it decides whether the write may go ahead, and if so which bits it may change. A request carries five things: its writer class, the descriptor currently stored, the proposed replacement, the descriptor's protected bit, and two second-stage attributes of the target page. The second-stage attributes are a mostly-read-only flag and an assured-only flag. One cycle later the block reports exactly one result:

- a commit strobe with the merged value to store,
- a permission fault, or
- a compare-failure status for a guarded atomic update whose expected old value did not match.

A programmable mask register names the fields that a guarded atomic update may change in a protected descriptor.

The block is a small result state machine with four states.

- `ST_IDLE`: no result this cycle.
- `ST_COMMIT`: a merged value is presented on `commit_data`.
- `ST_FAULT`: the write was rejected.
- `ST_CASFAIL`: a guarded update lost its compare.

The state machine moves on every clock, from any state, by these transitions:

- *no request* goes to `ST_IDLE`.
- *rejected* goes to `ST_FAULT`.
- *compare miss* goes to `ST_CASFAIL`.
- *accepted* goes to `ST_COMMIT`.

The merged value is registered alongside the state.

Top module: `descriptor_write_filter`

## Requirements
- R1: Every request's result appears exactly one cycle after the cycle in which `req_valid` was high. At most one of `commit_valid`, `perm_fault` and `cas_fail` is high in any cycle. All three are low in the cycle after a cycle with `req_valid` low.
- R2: A request with `s2_assured_only` high and `req_prot` low faults, whatever its writer class. This check takes priority over every other rule.
- R3: An ordinary store (`req_src` = 0) to a page with `s2_mostly_ro` high faults.
- R4: An ordinary store to a page with `s2_mostly_ro` low commits `new_desc` unchanged.
- R5: A hardware flag update (`req_src` = 1) commits even when `s2_mostly_ro` is high. It takes bit 10 (access flag) and bit 51 (dirty state) from `new_desc`, and every other bit from `cur_desc`.
- R6: A guarded atomic update (`req_src` = 2) whose `expect_desc` differs from `cur_desc` raises `cas_fail`. It raises neither a commit nor a fault.
- R7: A guarded atomic update with a matching compare and `req_prot` low commits `new_desc` unchanged, even when `s2_mostly_ro` is high.
- R8: A guarded atomic update with a matching compare and `req_prot` high takes from `new_desc` the bits set in the mask register, and keeps every other bit of `cur_desc`. The mask register resets to all zeros. It loads `mask_wdata` on a clock edge where `mask_we` is high, and governs requests issued in later cycles.
- R9: Writer class code 3 is reserved, and a request carrying it faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A write request is present this cycle |
| req_src | input | 2 | Writer class: 0 store, 1 hardware flag, 2 guarded atomic, 3 reserved |
| req_prot | input | 1 | Protected bit of the targeted descriptor |
| s2_mostly_ro | input | 1 | Second-stage mostly-read-only attribute of the page |
| s2_assured_only | input | 1 | Second-stage assured-only attribute of the page |
| cur_desc | input | 64 | Descriptor value currently stored |
| new_desc | input | 64 | Proposed descriptor value |
| expect_desc | input | 64 | Expected old value for a guarded atomic update |
| mask_we | input | 1 | Load the changeable-field mask |
| mask_wdata | input | 64 | New changeable-field mask |
| commit_valid | output | 1 | Commit strobe |
| commit_data | output | 64 | Merged value to store |
| perm_fault | output | 1 | Permission fault |
| cas_fail | output | 1 | Guarded update compare failed |

## Verification
The checker watches every cycle for four things:

- that the three result outputs are mutually exclusive and silent after an idle cycle,
- that assured-only violations and stores to mostly-read-only pages always fault,
- that hardware flag commits leave all bits except the two flag bits untouched,
- that protected guarded commits change only masked bits.

The checker cannot see the exact merged values or the compare-failure cases. The bench shows these through a sweep over every combination of writer class, protection, both page attributes and compare outcome, under two mask settings. The same sweep shows that guarded updates go through on mostly-read-only pages, and the reserved-code fault.

// File: rtl/descflt_pkg.sv
package descflt_pkg;

    typedef enum logic [1:0] {
        SRC_STORE   = 2'd0,
        SRC_HWFLAG  = 2'd1,
        SRC_GUARDED = 2'd2,
        SRC_RSVD    = 2'd3
    } wr_src_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMMIT  = 2'd1,
        ST_FAULT   = 2'd2,
        ST_CASFAIL = 2'd3
    } res_st_e;

endpackage

// File: rtl/descflt_decide.sv
module descflt_decide
    import descflt_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         valid,
    input  wr_src_e      src,
    input  logic         prot,
    input  logic         mostly_ro,
    input  logic         assured_only,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] expect_val,
    output res_st_e      nxt
);

    logic cmp_hit;

    assign cmp_hit = (cur == expect_val);

    always_comb begin
        nxt = ST_IDLE;
        if (!valid) begin
            nxt = ST_IDLE;
        end else if (assured_only && !prot) begin
            nxt = ST_FAULT;
        end else begin
            unique case (src)
                SRC_STORE:   nxt = mostly_ro ? ST_FAULT : ST_COMMIT;
                SRC_HWFLAG:  nxt = ST_COMMIT;
                SRC_GUARDED: nxt = cmp_hit ? ST_COMMIT : ST_CASFAIL;
                default:     nxt = ST_FAULT;
            endcase
        end
    end

endmodule

// File: rtl/descflt_merge.sv
module descflt_merge
    import descflt_pkg::*;
#(
    parameter int W         = 64,
    parameter int AF_POS    = 10,
    parameter int DIRTY_POS = 51
) (
    input  wr_src_e      src,
    input  logic         prot,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] proposed,
    input  logic [W-1:0] field_mask,
    output logic [W-1:0] merged
);

    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] HW_MASK = (ONE << AF_POS) | (ONE << DIRTY_POS);

    logic [W-1:0] take_new;

    always_comb begin
        unique case (src)
            SRC_HWFLAG:  take_new = HW_MASK;
            SRC_GUARDED: take_new = prot ? field_mask : {W{1'b1}};
            default:     take_new = {W{1'b1}};
        endcase
        merged = (cur & ~take_new) | (proposed & take_new);
    end

endmodule

// File: rtl/descriptor_write_filter.sv
module descriptor_write_filter
    import descflt_pkg::*;
#(
    parameter int W         = 64,
    parameter int AF_POS    = 10,
    parameter int DIRTY_POS = 51
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [1:0]   req_src,
    input  logic         req_prot,
    input  logic         s2_mostly_ro,
    input  logic         s2_assured_only,
    input  logic [W-1:0] cur_desc,
    input  logic [W-1:0] new_desc,
    input  logic [W-1:0] expect_desc,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic         commit_valid,
    output logic [W-1:0] commit_data,
    output logic         perm_fault,
    output logic         cas_fail
);

    wr_src_e      src;
    res_st_e      state_q;
    res_st_e      state_d;
    logic [W-1:0] mask_q;
    logic [W-1:0] merged;
    logic [W-1:0] data_q;

    assign src = wr_src_e'(req_src);

    descflt_decide #(.W(W)) u_decide (
        .valid        (req_valid),
        .src          (src),
        .prot         (req_prot),
        .mostly_ro    (s2_mostly_ro),
        .assured_only (s2_assured_only),
        .cur          (cur_desc),
        .expect_val   (expect_desc),
        .nxt          (state_d)
    );

    descflt_merge #(.W(W), .AF_POS(AF_POS), .DIRTY_POS(DIRTY_POS)) u_merge (
        .src        (src),
        .prot       (req_prot),
        .cur        (cur_desc),
        .proposed   (new_desc),
        .field_mask (mask_q),
        .merged     (merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_COMMIT) begin
                data_q <= merged;
            end
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
        end
    end

    always_comb begin
        commit_valid = 1'b0;
        perm_fault   = 1'b0;
        cas_fail     = 1'b0;
        unique case (state_q)
            ST_COMMIT:  commit_valid = 1'b1;
            ST_FAULT:   perm_fault   = 1'b1;
            ST_CASFAIL: cas_fail     = 1'b1;
            default:    ;
        endcase
        commit_data = data_q;
    end

endmodule

// File: rtl/descflt_chk.sv
module descflt_chk #(
    parameter int W         = 64,
    parameter int AF_POS    = 10,
    parameter int DIRTY_POS = 51
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [1:0]   req_src,
    input logic         req_prot,
    input logic         s2_mostly_ro,
    input logic         s2_assured_only,
    input logic [W-1:0] cur_desc,
    input logic [W-1:0] mask_q,
    input logic         commit_valid,
    input logic [W-1:0] commit_data,
    input logic         perm_fault,
    input logic         cas_fail
);

    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] HW_MASK = (ONE << AF_POS) | (ONE << DIRTY_POS);

    // R1
    exclusive_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_valid, perm_fault, cas_fail}));

    // R1
    quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(commit_valid || perm_fault || cas_fail));

    // R2
    assured_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && s2_assured_only && !req_prot) |=> perm_fault);

    // R3
    store_mostly_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 2'd0 && s2_mostly_ro) |=> perm_fault);

    // R5
    hwflag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 2'd1 && !(s2_assured_only && !req_prot))
        |=> (commit_valid && ((commit_data ^ $past(cur_desc)) & ~HW_MASK) == '0));

    // R8
    protected_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 2'd2 && req_prot)
        |=> (!commit_valid || ((commit_data ^ $past(cur_desc)) & ~$past(mask_q)) == '0));

endmodule

bind descriptor_write_filter descflt_chk #(.W(W), .AF_POS(AF_POS), .DIRTY_POS(DIRTY_POS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_src         (req_src),
    .req_prot        (req_prot),
    .s2_mostly_ro    (s2_mostly_ro),
    .s2_assured_only (s2_assured_only),
    .cur_desc        (cur_desc),
    .mask_q          (mask_q),
    .commit_valid    (commit_valid),
    .commit_data     (commit_data),
    .perm_fault      (perm_fault),
    .cas_fail        (cas_fail)
);

// File: tb/descriptor_write_filter_test.sv
`timescale 1ns/1ps
module descriptor_write_filter_test;

    localparam logic [63:0] HWM = (64'd1 << 10) | (64'd1 << 51);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_src = 2'd0;
    logic        req_prot = 1'b0;
    logic        s2_mostly_ro = 1'b0;
    logic        s2_assured_only = 1'b0;
    logic [63:0] cur_desc = '0;
    logic [63:0] new_desc = '0;
    logic [63:0] expect_desc = '0;
    logic        mask_we = 1'b0;
    logic [63:0] mask_wdata = '0;
    logic        commit_valid;
    logic [63:0] commit_data;
    logic        perm_fault;
    logic        cas_fail;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mask_model = '0;

    always #2.5 clk = ~clk;

    descriptor_write_filter uut (.*);

    task automatic check(input string tag, input logic c, input logic f, input logic x,
                         input logic [63:0] d);
        n_chk++;
        if (commit_valid !== c || perm_fault !== f || cas_fail !== x ||
            (c && commit_data !== d)) begin
            n_bad++;
            $display("FAIL %s: got c=%b f=%b x=%b d=%h, expected c=%b f=%b x=%b d=%h",
                     tag, commit_valid, perm_fault, cas_fail, commit_data, c, f, x, d);
        end
    endtask

    task automatic apply(input int code, input int phase);
        logic c, f, x;
        logic [63:0] d;
        logic [63:0] cur, nw, ex;
        string tag;
        cur = {32'(code) * 32'h9E37_79B9, 32'(phase + 7) * 32'h85EB_CA6B};
        nw  = ~cur ^ {32'(code) * 32'h0101_0101, 32'hC2B2_AE35};
        ex  = code[5] ? cur : (cur ^ (64'd1 << code));
        req_valid = 1'b1; req_src = code[1:0]; req_prot = code[2];
        s2_mostly_ro = code[3]; s2_assured_only = code[4];
        cur_desc = cur; new_desc = nw; expect_desc = ex;
        c = 0; f = 0; x = 0; d = '0;
        if (code[4] && !code[2]) begin f = 1; tag = "R2"; end
        else case (code[1:0])
            2'd0: if (code[3]) begin f = 1; tag = "R3"; end
                  else begin c = 1; d = nw; tag = "R4"; end
            2'd1: begin c = 1; d = (cur & ~HWM) | (nw & HWM); tag = "R5"; end
            2'd2: if (!code[5]) begin x = 1; tag = "R6"; end
                  else if (!code[2]) begin c = 1; d = nw; tag = "R7"; end
                  else begin c = 1; d = (cur & ~mask_model) | (nw & mask_model); tag = "R8"; end
            default: begin f = 1; tag = "R9"; end
        endcase
        @(negedge clk);
        check(tag, c, f, x, d);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: expired, expected run to finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 0, 0, 0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int code = 0; code < 64; code++) apply(code, 0);
        // R8: change mask, then sweep again
        req_valid = 1'b0; mask_we = 1'b1; mask_wdata = 64'h00FF_0000_F0F0_1234;
        s2_assured_only = 1'b1; req_src = 2'd3;
        @(negedge clk);
        mask_model = 64'h00FF_0000_F0F0_1234;
        mask_we = 1'b0;
        check("R1 idle", 0, 0, 0, '0);
        for (int code = 0; code < 64; code++) apply(code, 1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 idle end", 0, 0, 0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule